// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This block takes two packed single-precision IEEE-754 words, a left operand and a right operand, and reports their relation as a 4-bit condition code laid out N, Z, C, V (bit 3 down to bit 0). It also reports an invalid-operation flag. A zero-select input makes the right operand +0, which gives a compare against zero. A strict input selects the compare variant that also raises invalid-operation on quiet NaNs. Subnormal values are ordered by their bit patterns. They are not flushed to zero.

The result is registered. The caller holds `in_valid` high for one cycle with the operands and controls. On the next clock edge the result is loaded and `out_valid` rises. A small two-state machine drives this handshake. In `ST_IDLE` no result is being presented. The transition `IDLE_TO_RESULT` happens when `in_valid` is high. In `ST_RESULT` the result just captured is presented for one cycle. From there, `RESULT_TO_RESULT` follows a new `in_valid` and `RESULT_TO_IDLE` follows its absence. The result registers keep their last value until the next request.

Top module: `fcmp_nzcv`

## Requirements
- R1: While `out_valid` is high, `nzcv` is exactly one of four codes: less = 4'b1000, equal = 4'b0110, greater = 4'b0010, unordered = 4'b0011 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V).
- R2: A NaN is a word whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is non-zero. If either operand is a NaN, the code is unordered.
- R3: A signalling NaN operand (fraction bit 22 clear) sets `invalid`, whatever the value of `strict`.
- R4: A quiet NaN operand (fraction bit 22 set) sets `invalid` only when `strict` is 1.
- R5: Non-NaN operands with identical bit patterns compare equal. Operands whose bits 30:0 are all zero in both words (+0 and -0 in any mix) also compare equal.
- R6: When the sign bits (bit 31) differ and the values are not equal, the operand with the sign bit set is the lesser.
- R7: When the sign bits match, the order is the unsigned order of the 32-bit words, reversed when both are negative. This ordering covers subnormals and infinities, and neither raises `invalid`.
- R8: With `zero_sel` = 1 the right operand is +0 (32'h0000_0000). The `op_b` input then has no effect on `nzcv` or `invalid`, even when it holds a NaN.
- R9: After reset `out_valid`, `nzcv` and `invalid` are 0. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the result of that request appears in that same cycle.
- R10: `invalid` is raised only together with the unordered code. It never changes which code is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request: operands and controls are valid this cycle |
| op_a | input | 32 | Left operand, packed single precision |
| op_b | input | 32 | Right operand, packed single precision |
| zero_sel | input | 1 | Compare `op_a` against +0 instead of `op_b` |
| strict | input | 1 | Raise invalid-operation on quiet NaNs as well |
| out_valid | output | 1 | Result presented this cycle |
| nzcv | output | 4 | Condition code N,Z,C,V |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The operand pairs are chosen to separate the branches of the compare:
- Positive pairs and negative pairs in both orders show whether the unsigned word order is reversed for negatives.
- Mixed-sign pairs exercise the rule that the negative operand is the lesser.
- +0 against -0 separates the magnitude-zero equality from bit-pattern equality.
- Quiet and signalling NaNs, on each side and with `strict` at both values, separate the unordered code from the invalid flag.
- Infinities and subnormals check that these values are ordered normally and raise no exception.
- A zero-select case with a NaN on `op_b` shows that the ignored input cannot reach the result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    localparam logic [3:0] CC_LT = 4'b1000;
    localparam logic [3:0] CC_EQ = 4'b0110;
    localparam logic [3:0] CC_GT = 4'b0010;
    localparam logic [3:0] CC_UN = 4'b0011;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] word,
    output logic         is_nan,
    output logic         is_quiet
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f    = word[W-2 -: EXP_W];
    assign frac_f   = word[FRAC_W-1:0];
    assign is_nan   = (&exp_f) && (|frac_f);
    assign is_quiet = frac_f[FRAC_W-1];
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         any_nan,
    output rel_e         rel
);
    logic sign_l, sign_r, both_zero, lhs_below;

    assign sign_l    = lhs[W-1];
    assign sign_r    = rhs[W-1];
    assign both_zero = ((lhs[W-2:0] | rhs[W-2:0]) == '0);
    assign lhs_below = (lhs < rhs);

    always_comb begin
        if (any_nan) begin
            rel = REL_UN;
        end else if (lhs == rhs || both_zero) begin
            rel = REL_EQ;
        end else if (sign_l != sign_r) begin
            rel = sign_l ? REL_LT : REL_GT;
        end else if (sign_l ^ lhs_below) begin
            rel = REL_LT;
        end else begin
            rel = REL_GT;
        end
    end
endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         zero_sel,
    input  logic         strict,
    output logic         out_valid,
    output logic [3:0]   nzcv,
    output logic         invalid
);
    state_e state_q, state_d;
    logic [W-1:0] rhs;
    logic [W-1:0] opnd [2];
    logic [1:0]   nan_v, quiet_v, raise_v;
    rel_e         rel;
    logic [3:0]   cc_d;
    logic         inv_d;
    logic [3:0]   cc_q;
    logic         inv_q;

    assign rhs     = zero_sel ? '0 : op_b;
    assign opnd[0] = op_a;
    assign opnd[1] = rhs;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word    (opnd[i]),
            .is_nan  (nan_v[i]),
            .is_quiet(quiet_v[i])
        );
        assign raise_v[i] = nan_v[i] && (strict || !quiet_v[i]);
    end

    fcmp_relate #(.W(W)) u_rel (
        .lhs    (op_a),
        .rhs    (rhs),
        .any_nan(|nan_v),
        .rel    (rel)
    );

    always_comb begin
        unique case (rel)
            REL_LT:  cc_d = CC_LT;
            REL_EQ:  cc_d = CC_EQ;
            REL_GT:  cc_d = CC_GT;
            default: cc_d = CC_UN;
        endcase
        inv_d = |raise_v;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q  <= '0;
            inv_q <= 1'b0;
        end else if (in_valid) begin
            cc_q  <= cc_d;
            inv_q <= inv_d;
        end
    end

    assign out_valid = (state_q == ST_RESULT);
    assign nzcv      = cc_q;
    assign invalid   = inv_q;
endmodule

// File: rtl/fcmp_nzcv_chk.sv
module fcmp_nzcv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        zero_sel,
    input logic        strict,
    input logic        out_valid,
    input logic [3:0]  nzcv,
    input logic        invalid
);
    logic [31:0] eff_b;
    logic a_nan, b_nan, a_snan, b_snan;

    assign eff_b  = zero_sel ? 32'h0 : op_b;
    assign a_nan  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 0);
    assign b_nan  = (eff_b[30:23] == 8'hFF) && (eff_b[22:0] != 0);
    assign a_snan = a_nan && !op_a[22];
    assign b_snan = b_nan && !eff_b[22];

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nzcv == 4'b1000 || nzcv == 4'b0110 || nzcv == 4'b0010 || nzcv == 4'b0011));

    assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_nan || b_nan)) |=> (nzcv == 4'b0011));

    assert_snan_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_snan || b_snan)) |=> invalid);

    assert_strict_qnan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && strict && (a_nan || b_nan)) |=> invalid);

    assert_same_bits_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !a_nan && op_a == eff_b) |=> (nzcv == 4'b0110));

    assert_zero_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_sel && op_a[30:0] == 31'h0) |=> (nzcv == 4'b0110 && !invalid));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_invalid_only_unordered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> (nzcv == 4'b0011));
endmodule

bind fcmp_nzcv fcmp_nzcv_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .zero_sel (zero_sel),
    .strict   (strict),
    .out_valid(out_valid),
    .nzcv     (nzcv),
    .invalid  (invalid)
);

// File: tb/tb_fcmp_nzcv.sv
module tb_fcmp_nzcv;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // vector fields: op_a[70:39] op_b[38:7] zero_sel[6] strict[5] nzcv[4:1] invalid[0]
    localparam logic [70:0] VEC [NVEC] = '{
        {32'h3F80_0000, 32'h4000_0000, 1'b0, 1'b0, 4'b1000, 1'b0}, // R7 pos less
        {32'h4000_0000, 32'h3F80_0000, 1'b0, 1'b0, 4'b0010, 1'b0}, // R7 pos greater
        {32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, 4'b0110, 1'b0}, // R5 same bits
        {32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'b0110, 1'b0}, // R5 -0 vs +0
        {32'hBF80_0000, 32'h3F80_0000, 1'b0, 1'b0, 4'b1000, 1'b0}, // R6 neg first
        {32'h3F80_0000, 32'hBF80_0000, 1'b0, 1'b0, 4'b0010, 1'b0}, // R6 neg second
        {32'hC000_0000, 32'hBF80_0000, 1'b0, 1'b0, 4'b1000, 1'b0}, // R7 neg reversed
        {32'hBF80_0000, 32'hC000_0000, 1'b0, 1'b0, 4'b0010, 1'b0}, // R7 neg reversed
        {32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b0, 4'b0011, 1'b0}, // R2 R4 qnan quiet
        {32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b1, 4'b0011, 1'b1}, // R4 strict qnan
        {32'h3F80_0000, 32'h7F80_0001, 1'b0, 1'b0, 4'b0011, 1'b1}, // R3 snan rhs
        {32'h7F80_0000, 32'h7F7F_FFFF, 1'b0, 1'b0, 4'b0010, 1'b0}, // R7 inf vs max
        {32'hFF80_0000, 32'hFF80_0000, 1'b0, 1'b0, 4'b0110, 1'b0}, // R5 -inf equal
        {32'h0000_0001, 32'h0000_0002, 1'b0, 1'b0, 4'b1000, 1'b0}, // R7 subnormal
        {32'h8000_0001, 32'h7FC0_0000, 1'b1, 1'b1, 4'b1000, 1'b0}, // R8 nan ignored
        {32'h7F80_0000, 32'hFF80_0000, 1'b0, 1'b0, 4'b0010, 1'b0}, // R6 inf signs
        {32'hFFC0_0000, 32'h7FC0_0000, 1'b0, 1'b0, 4'b0011, 1'b0}, // R10 R2 both qnan
        {32'h0000_0000, 32'hFF80_0000, 1'b1, 1'b0, 4'b0110, 1'b0}  // R8 zero vs +0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        zero_sel = 1'b0;
    logic        strict = 1'b0;
    logic        out_valid;
    logic [3:0]  nzcv;
    logic        invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_nzcv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .zero_sel(zero_sel), .strict(strict), .out_valid(out_valid),
        .nzcv(nzcv), .invalid(invalid)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic zs,
                       input logic st, input logic [3:0] cc, input logic inv, input string req);
        @(negedge clk);
        op_a = a; op_b = b; zero_sel = zs; strict = st; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        op_b = 32'h7F80_0001;
        check(req, {out_valid, nzcv, invalid}, {1'b1, cc, inv});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", {out_valid, nzcv, invalid}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle", {out_valid, nzcv, invalid}, 6'b0);
        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i][70:39], VEC[i][38:7], VEC[i][6], VEC[i][5], VEC[i][4:1], VEC[i][0],
                $sformatf("R1 vector %0d", i));
        end
        // R9 out_valid drops one cycle after the request, result held
        @(negedge clk);
        check("R9 drop", {out_valid, nzcv, invalid}, {1'b0, 4'b0110, 1'b0});
        // R9 back-to-back requests
        @(negedge clk);
        op_a = 32'h4000_0000; op_b = 32'h3F80_0000; zero_sel = 0; strict = 0; in_valid = 1;
        @(negedge clk);
        check("R9 b2b first", {out_valid, nzcv, invalid}, {1'b1, 4'b0010, 1'b0});
        op_a = 32'h7F80_0001; op_b = 32'h3F80_0000;
        @(negedge clk);
        in_valid = 0;
        check("R3 b2b snan", {out_valid, nzcv, invalid}, {1'b1, 4'b0011, 1'b1});
        // R8 zero_sel against negative value
        run(32'hBF80_0000, 32'hC000_0000, 1'b1, 1'b0, 4'b1000, 1'b0, "R8 neg vs zero");
        // R6 R8 positive vs zero with strict and nan on op_b
        run(32'h0000_0001, 32'hFF80_0001, 1'b1, 1'b1, 4'b0010, 1'b0, "R8 R6 pos vs zero");
        // R10 strict on ordered pair raises nothing
        run(32'hFF80_0000, 32'h0000_0000, 1'b0, 1'b1, 4'b1000, 1'b0, "R10 strict ordered");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule